// File: doc/BRIEF.md
# Doubleword Memory Access Sequencer

This block sits between a processor's memory address register and a store that is 32 bits wide. A load strobe captures an address. If the address is in range, the block fetches the doubleword that holds it into a read latch and a write latch in the same cycle. Reads then return one 16-bit half of the read latch. Writes merge a 16-bit word into the write latch and store the whole doubleword back.

After each word the low address bit flips, so the partner word of the pair can follow without a second load. An access that arrives too long after the load is refused and cancelled. Addresses whose low 16 bits fall in the I/O page are not served from the store. They are handed to an external register port and end the access.

A configuration input exchanges the lower and upper 32K-word halves of the store. It acts on the physical doubleword address only.

Top module: `dword_mem_seq`

## Requirements
- R1: After reset no access is open, `rd_data` is 0 and `fault` is low.
- R2: A load of an address below `RAM_WORDS` places the doubleword at address/2 in both the read and write latches and opens an access.
- R3: A load strobe whose select equals 5'o37 is a refresh and changes nothing: an open access and its window continue, and with no open access a following read faults.
- R4: A read returns bits [31:16] of the read latch when address bit 0 is 0, and bits [15:0] when it is 1. The value appears on `rd_data` in the cycle after the strobe.
- R5: The first read of an access flips address bit 0 without using up window time. The second read closes the access, so a third read faults.
- R6: A read or write with no open access pulses `fault` in the following cycle. Such a read returns 16'hFFFF and such a write stores nothing.
- R7: The strobe age is the number of cycles since the load, less one for each completed first word. A read or write at an age above `WINDOW` (4) faults, returns 16'hFFFF for a read, and cancels the access.
- R8: A load at or above `RAM_WORDS` opens an access whose latches hold all ones. Reads return 16'hFFFF without a fault, and writes never assert `ram_we`.
- R9: A read or write whose low 16 address bits are at or above `IO_BASE` (16'hFE00) drives `io_req` and ends the access. A read with `io_hit` low returns 16'hFFFF.
- R10: A write merges `wr_data` into the half chosen by address bit 0 and stores the whole write latch. It then flips bit 0 so the partner word can also be written.
- R11: With `swap_halves` high, bit 14 of the physical doubleword address is inverted. This exchanges the first and second 32K words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Address load strobe (highest priority) |
| ld_sel | input | SEL_W | Register select that comes with the load; 5'o37 means refresh |
| ld_addr | input | ADDR_W | Word address to load |
| rd_en | input | 1 | Read strobe (above write) |
| rd_data | output | 16 | Word returned by the last read |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Word to write |
| fault | output | 1 | One-cycle pulse after a refused read or write |
| swap_halves | input | 1 | Exchange the two 32K-word halves |
| ram_addr | output | ADDR_W-1 | Physical doubleword address |
| ram_rdata | input | 32 | Store read data for ram_addr, same cycle |
| ram_we | output | 1 | Store write enable |
| ram_wdata | output | 32 | Doubleword to store |
| io_req | output | 1 | I/O page access this cycle |
| io_we | output | 1 | I/O access is a write |
| io_addr | output | 16 | I/O page address |
| io_wdata | output | 16 | I/O write data |
| io_rdata | input | 16 | I/O read data |
| io_hit | input | 1 | I/O address is mapped |

## Verification
The hardest condition to reach is the age window after a first word has been used. The partner read must land exactly at age four to pass and exactly at age five to fault, and the age depends on the earlier read having held the counter. The bench issues every strobe as a single-cycle pulse and counts idle cycles between strobes by hand. This puts the second word at both edges of the window. A refresh load is also placed between a load and its read, to show that the refresh leaves the window running.

// File: rtl/dws_pkg.sv
package dws_pkg;
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_RAM  = 2'd1,
        ACC_VOID = 2'd2
    } acc_e;
endpackage

// File: rtl/dws_addr_map.sv
module dws_addr_map #(
    parameter int ADDR_W     = 17,
    parameter int RAM_WORDS  = 65536,
    parameter int HALF_WORDS = 32768
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              swap,
    output logic              in_ram,
    output logic [ADDR_W-2:0] phys_dw
);
    // bit of the doubleword address that selects the 32K-word half
    localparam int SWAP_BIT = $clog2(HALF_WORDS) - 1;
    localparam logic [ADDR_W-2:0] SWAP_MASK = (ADDR_W-1)'(1) << SWAP_BIT;

    always_comb begin
        in_ram  = 32'(addr) < 32'(RAM_WORDS);
        phys_dw = addr[ADDR_W-1:1] ^ (swap ? SWAP_MASK : '0);
    end
endmodule

// File: rtl/dws_window.sv
module dws_window #(
    parameter int WINDOW = 4,
    parameter int AGE_W  = 3
) (
    input  logic [AGE_W-1:0] age_q,
    input  logic             start,
    input  logic             hold,
    output logic             late,
    output logic [AGE_W-1:0] age_d
);
    always_comb begin
        late = 32'(age_q) > 32'(WINDOW);
        if (start)
            age_d = AGE_W'(1);
        else if (hold)
            age_d = age_q;               // cycle passes, stamp advances: age unchanged
        else if (&age_q)
            age_d = age_q;               // saturate
        else
            age_d = age_q + AGE_W'(1);
    end
endmodule

// File: rtl/dws_half.sv
module dws_half (
    input  logic [31:0] rlat,
    input  logic [31:0] wlat,
    input  logic        odd,
    input  logic [15:0] wdata,
    output logic [15:0] rhalf,
    output logic [31:0] merged
);
    always_comb begin
        rhalf  = odd ? rlat[15:0] : rlat[31:16];
        merged = odd ? {wlat[31:16], wdata} : {wdata, wlat[15:0]};
    end
endmodule

// File: rtl/dword_mem_seq.sv
module dword_mem_seq
    import dws_pkg::*;
#(
    parameter int                ADDR_W      = 17,
    parameter int                RAM_WORDS   = 65536,
    parameter int                HALF_WORDS  = 32768,
    parameter int                WINDOW      = 4,
    parameter int                SEL_W       = 5,
    parameter logic [SEL_W-1:0]  REFRESH_SEL = 5'o37,
    parameter logic [15:0]       IO_BASE     = 16'hFE00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [SEL_W-1:0]  ld_sel,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              rd_en,
    output logic [15:0]       rd_data,
    input  logic              wr_en,
    input  logic [15:0]       wr_data,
    output logic              fault,
    input  logic              swap_halves,
    output logic [ADDR_W-2:0] ram_addr,
    input  logic [31:0]       ram_rdata,
    output logic              ram_we,
    output logic [31:0]       ram_wdata,
    output logic              io_req,
    output logic              io_we,
    output logic [15:0]       io_addr,
    output logic [15:0]       io_wdata,
    input  logic [15:0]       io_rdata,
    input  logic              io_hit
);
    localparam int          AGE_W    = $clog2(WINDOW + 2);
    localparam logic [15:0] ALL_ONES = 16'hFFFF;

    typedef struct packed {
        acc_e              acc;
        logic              second;
        logic [ADDR_W-1:0] mar;
        logic [31:0]       rlat;
        logic [31:0]       wlat;
        logic [AGE_W-1:0]  age;
        logic [15:0]       rdat;
        logic              flt;
    } st_t;

    st_t st_q, st_d;

    logic              ld_go;
    logic              mar_io;
    logic              step;
    logic              late;
    logic [AGE_W-1:0]  age_d;
    logic              map_in_ram;
    logic [ADDR_W-1:0] map_addr;
    logic [15:0]       rhalf;
    logic [31:0]       merged;

    assign ld_go    = ld_en && (ld_sel != REFRESH_SEL);
    assign mar_io   = st_q.mar[15:0] >= IO_BASE;
    assign map_addr = ld_go ? ld_addr : st_q.mar;
    assign step     = !ld_en && (rd_en || wr_en) && (st_q.acc != ACC_NONE)
                      && !late && !mar_io;

    dws_addr_map #(
        .ADDR_W    (ADDR_W),
        .RAM_WORDS (RAM_WORDS),
        .HALF_WORDS(HALF_WORDS)
    ) u_map (
        .addr   (map_addr),
        .swap   (swap_halves),
        .in_ram (map_in_ram),
        .phys_dw(ram_addr)
    );

    dws_window #(
        .WINDOW(WINDOW),
        .AGE_W (AGE_W)
    ) u_win (
        .age_q(st_q.age),
        .start(ld_go),
        .hold (step),
        .late (late),
        .age_d(age_d)
    );

    dws_half u_half (
        .rlat  (st_q.rlat),
        .wlat  (st_q.wlat),
        .odd   (st_q.mar[0]),
        .wdata (wr_data),
        .rhalf (rhalf),
        .merged(merged)
    );

    always_comb begin
        st_d     = st_q;
        st_d.flt = 1'b0;
        st_d.age = age_d;
        ram_we    = 1'b0;
        ram_wdata = merged;
        io_req    = 1'b0;
        io_we     = 1'b0;
        io_addr   = st_q.mar[15:0];
        io_wdata  = wr_data;

        if (ld_en) begin
            if (ld_go) begin
                st_d.mar    = ld_addr;
                st_d.second = 1'b0;
                if (map_in_ram) begin
                    st_d.acc  = ACC_RAM;
                    st_d.rlat = ram_rdata;
                    st_d.wlat = ram_rdata;
                end else begin
                    st_d.acc  = ACC_VOID;
                    st_d.rlat = '1;
                    st_d.wlat = '1;
                end
            end
        end else if (rd_en) begin
            if (st_q.acc == ACC_NONE || late) begin
                st_d.flt  = 1'b1;
                st_d.rdat = ALL_ONES;
                st_d.acc  = ACC_NONE;
            end else if (mar_io) begin
                io_req    = 1'b1;
                st_d.rdat = io_hit ? io_rdata : ALL_ONES;
                st_d.acc  = ACC_NONE;
            end else begin
                st_d.rdat = rhalf;
                if (st_q.second) begin
                    st_d.acc = ACC_NONE;
                end else begin
                    st_d.mar[0] = ~st_q.mar[0];
                    st_d.second = 1'b1;
                end
            end
        end else if (wr_en) begin
            if (st_q.acc == ACC_NONE || late) begin
                st_d.flt = 1'b1;
                st_d.acc = ACC_NONE;
            end else if (mar_io) begin
                io_req   = 1'b1;
                io_we    = 1'b1;
                st_d.acc = ACC_NONE;
            end else begin
                st_d.wlat   = merged;
                ram_we      = (st_q.acc == ACC_RAM);
                st_d.mar[0] = ~st_q.mar[0];
                st_d.second = ~st_q.second;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rd_data = st_q.rdat;
    assign fault   = st_q.flt;
endmodule

// File: rtl/dws_chk.sv
module dws_chk #(
    parameter logic [15:0] IO_BASE = 16'hFE00
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ld_en,
    input logic        rd_en,
    input logic        wr_en,
    input logic        fault,
    input logic [15:0] rd_data,
    input logic        ram_we,
    input logic        io_req,
    input logic        io_we,
    input logic        io_hit,
    input logic [15:0] io_addr
);
    // R10
    ram_we_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (wr_en && !ld_en));

    // R9
    io_req_in_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_req |-> ((io_addr >= IO_BASE) && (rd_en || wr_en) && !ld_en));

    // R6
    fault_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !wr_en) |=> !fault);

    // R6
    refused_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !ld_en) |=> (!fault || rd_data == 16'hFFFF));

    // R9
    unmapped_io_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && !io_we && !io_hit) |=> (rd_data == 16'hFFFF && !fault));
endmodule

bind dword_mem_seq dws_chk #(.IO_BASE(IO_BASE)) u_dws_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_en  (ld_en),
    .rd_en  (rd_en),
    .wr_en  (wr_en),
    .fault  (fault),
    .rd_data(rd_data),
    .ram_we (ram_we),
    .io_req (io_req),
    .io_we  (io_we),
    .io_hit (io_hit),
    .io_addr(io_addr)
);

// File: tb/test_dword_mem_seq.sv
`timescale 1ns/1ps
module test_dword_mem_seq;
    localparam int ADDR_W = 17;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ld_en = 1'b0;
    logic [4:0]        ld_sel = '0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic              rd_en = 1'b0;
    logic [15:0]       rd_data;
    logic              wr_en = 1'b0;
    logic [15:0]       wr_data = '0;
    logic              fault;
    logic              swap_halves = 1'b0;
    logic [ADDR_W-2:0] ram_addr;
    logic [31:0]       ram_rdata;
    logic              ram_we;
    logic [31:0]       ram_wdata;
    logic              io_req, io_we;
    logic [15:0]       io_addr, io_wdata, io_rdata;
    logic              io_hit;

    int n_cmp = 0;
    int n_bad = 0;
    int n_ram_wr = 0;
    logic [15:0] last_io_wr = '0;
    logic        io_seen = 1'b0;
    bit          done = 1'b0;

    logic [15:0] ov_a [8];
    logic [31:0] ov_d [8];
    logic        ov_v [8];

    always #5 clk = ~clk;

    dword_mem_seq i_dword_mem_seq (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr),
        .rd_en(rd_en), .rd_data(rd_data), .wr_en(wr_en), .wr_data(wr_data),
        .fault(fault), .swap_halves(swap_halves), .ram_addr(ram_addr),
        .ram_rdata(ram_rdata), .ram_we(ram_we), .ram_wdata(ram_wdata),
        .io_req(io_req), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_hit(io_hit)
    );

    function automatic logic [31:0] patt(logic [15:0] dw);
        return {dw ^ 16'h5A3C, ~dw + 16'h0101};
    endfunction

    function automatic logic [15:0] half(logic [31:0] d, logic odd);
        return odd ? d[15:0] : d[31:16];
    endfunction

    always_comb begin
        ram_rdata = patt(ram_addr);
        for (int i = 0; i < 8; i++)
            if (ov_v[i] && ov_a[i] == ram_addr) ram_rdata = ov_d[i];
    end

    assign io_hit   = (io_addr == 16'hFE10);
    assign io_rdata = 16'h1234;

    always @(posedge clk) begin
        if (ram_we) begin
            automatic bit placed = 1'b0;
            n_ram_wr++;
            for (int i = 0; i < 8; i++)
                if (!placed && ov_v[i] && ov_a[i] == ram_addr) begin
                    ov_d[i] = ram_wdata; placed = 1'b1;
                end
            for (int i = 0; i < 8; i++)
                if (!placed && !ov_v[i]) begin
                    ov_v[i] = 1'b1; ov_a[i] = ram_addr; ov_d[i] = ram_wdata; placed = 1'b1;
                end
        end
        if (io_req) io_seen = 1'b1;
        if (io_req && io_we) last_io_wr = io_wdata;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic ld(logic [ADDR_W-1:0] a, logic [4:0] sel = 5'd0);
        ld_en = 1'b1; ld_addr = a; ld_sel = sel;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic rd();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(logic [15:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [ADDR_W-1:0] addrs [22];
        int wc;
        for (int i = 0; i < 8; i++) begin ov_v[i] = 1'b0; ov_a[i] = '0; ov_d[i] = '0; end
        for (int i = 0; i < 16; i++) addrs[i] = ADDR_W'(i);
        addrs[16] = 17'h07FFE; addrs[17] = 17'h07FFF; addrs[18] = 17'h08000;
        addrs[19] = 17'h08001; addrs[20] = 17'h0FDFE; addrs[21] = 17'h0FDFF;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rd_data", 32'(rd_data), 32'h0);
        check("R1 fault", 32'(fault), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 strobes with no access
        rd();
        check("R6 fault on bare read", 32'(fault), 32'h1);
        check("R6 bare read data", 32'(rd_data), 32'hFFFF);
        wc = n_ram_wr;
        wr(16'h1111);
        check("R6 fault on bare write", 32'(fault), 32'h1);
        check("R6 bare write stores nothing", 32'(n_ram_wr), 32'(wc));

        // R3 refresh opens nothing
        ld(17'd4, 5'o37);
        rd();
        check("R3 refresh no access", 32'(fault), 32'h1);
        // R3 refresh keeps an open access
        ld(17'd6);
        ld(17'd8, 5'o37);
        rd();
        check("R3 access survives refresh", 32'(rd_data), 32'(half(patt(16'd3), 1'b0)));
        check("R3 no fault", 32'(fault), 32'h0);

        // R2 R4 R5 sweep over start addresses
        for (int k = 0; k < 22; k++) begin
            logic [15:0] dw;
            logic        od;
            dw = addrs[k][16:1];
            od = addrs[k][0];
            ld(addrs[k]);
            rd();
            check("R4 first word", 32'(rd_data), 32'(half(patt(dw), od)));
            check("R2 first no fault", 32'(fault), 32'h0);
            rd();
            check("R5 partner word", 32'(rd_data), 32'(half(patt(dw), ~od)));
            rd();
            check("R5 pair closed", 32'(fault), 32'h1);
        end

        // R7 window from load
        ld(17'd10); idle(3); rd();
        check("R7 age four passes", 32'(fault), 32'h0);
        check("R7 age four data", 32'(rd_data), 32'(half(patt(16'd5), 1'b0)));
        ld(17'd10); idle(4); rd();
        check("R7 age five faults", 32'(fault), 32'h1);
        check("R7 late data", 32'(rd_data), 32'hFFFF);
        rd();
        check("R7 access cancelled", 32'(fault), 32'h1);
        // R7 partner word window
        ld(17'd12); rd(); idle(3); rd();
        check("R7 partner at four", 32'(rd_data), 32'(half(patt(16'd6), 1'b1)));
        ld(17'd12); rd(); idle(4); rd();
        check("R7 partner at five", 32'(fault), 32'h1);

        // R8 out of range
        ld(17'h10004); rd();
        check("R8 void read", 32'(rd_data), 32'hFFFF);
        check("R8 void no fault", 32'(fault), 32'h0);
        wc = n_ram_wr;
        ld(17'h10006); wr(16'h2222); wr(16'h3333);
        check("R8 void write not stored", 32'(n_ram_wr), 32'(wc));
        check("R8 void write no fault", 32'(fault), 32'h0);

        // R9 I/O page
        io_seen = 1'b0;
        ld(17'h0FE10); rd();
        check("R9 mapped io read", 32'(rd_data), 32'h1234);
        check("R9 io_req seen", 32'(io_seen), 32'h1);
        rd();
        check("R9 io ends access", 32'(fault), 32'h1);
        ld(17'h0FE11); rd();
        check("R9 unmapped io", 32'(rd_data), 32'hFFFF);
        check("R9 unmapped no fault", 32'(fault), 32'h0);
        ld(17'h1FE10); rd();
        check("R9 io on low 16 bits", 32'(rd_data), 32'h1234);
        wc = n_ram_wr;
        ld(17'h0FE10); wr(16'hBEEF);
        check("R9 io write data", 32'(last_io_wr), 32'hBEEF);
        check("R9 io write not stored", 32'(n_ram_wr), 32'(wc));

        // R10 write pair and merge
        wc = n_ram_wr;
        ld(17'h00040); wr(16'hAAAA); wr(16'h5555);
        check("R10 two stores", 32'(n_ram_wr), 32'(wc + 2));
        ld(17'h00040); rd();
        check("R10 even written", 32'(rd_data), 32'hAAAA);
        rd();
        check("R10 odd written", 32'(rd_data), 32'h5555);
        ld(17'h00041); wr(16'h7777); rd();
        check("R10 read latch kept", 32'(rd_data), 32'hAAAA);
        ld(17'h00040); rd(); rd();
        check("R10 odd merge", 32'(rd_data), 32'h7777);
        ld(17'h00050); wr(16'h0F0F); rd();
        check("R10 read after write uses old latch", 32'(rd_data),
              32'(half(patt(16'h0028), 1'b1)));

        // R11 half swap
        swap_halves = 1'b1;
        ld(17'd2); rd();
        check("R11 swapped low", 32'(rd_data), 32'(half(patt(16'h4001), 1'b0)));
        ld(17'h08000); rd();
        check("R11 swapped high", 32'(rd_data), 32'(half(patt(16'h0000), 1'b0)));
        ld(17'd4); wr(16'hC0DE);
        swap_halves = 1'b0;
        ld(17'h08004); rd();
        check("R11 swapped write", 32'(rd_data), 32'hC0DE);

        done = 1'b1;
        summary();
    end
endmodule